// File: doc/BRIEF.md
# Receive Ramp Pattern Checker

This block sits on one receive lane after symbol decoding and rate-matching buffering. While a self-test is running, the far-end transmitter sends a repeating frame: one or more idle control characters, then an incrementing byte ramp that runs through every data value from zero to all-ones. Each cycle the checker takes the decoded byte, a flag saying whether that byte is a control character, and a flag for any receive fault (a code violation or a buffer fault). It reduces all of this to a single error-status bit. Low means frames are arriving intact. High means the pattern has not yet been seen complete, or has been broken.

The status starts high. It drops only when an idle run is followed by a complete, fault-free ramp. Any departure from the pattern raises it again. The checker then waits for the next idle and looks for a fresh ramp starting at zero. Rate matching upstream may add or remove idles, so the idle run between ramps may have any length of one or more. Every lane has its own instance and no alignment is attempted between lanes. The received byte and flags are also forwarded unchanged, so normal traffic monitoring still works during the test.

Top module: `ramp_pattern_checker`

## Requirements
- R1: On the first cycle that `test_en` is sampled high after being low (or after reset), `err_status` is high in the following cycle. A ramp that was partly received before `test_en` dropped never clears the status after it rises again.
- R2: An idle symbol is `rx_ctrl`=1 with `rx_byte`=0xBC (default `IDLE_CODE`). After at least one idle followed by the data bytes 0x00, 0x01, … 0xFF in consecutive cycles, all with `rx_ctrl`=0 and `rx_fault`=0, `err_status` is low in the cycle after the 0xFF byte is sampled.
- R3: A data byte that differs from the expected ramp value sets `err_status` high in the cycle after it is sampled.
- R4: With `test_en` high, a cycle with `rx_fault`=1 sets `err_status` high in the next cycle, whatever the byte and control flag are.
- R5: Any idle run of length one or more between ramps is accepted. While consecutive good frames arrive, `err_status` stays low.
- R6: The symbol after the 0xFF byte must be an idle. A data byte in that position, including a zero-idle gap straight into 0x00, sets `err_status` high.
- R7: After an error, `err_status` stays high through the rest of the broken ramp. It drops again only after a later idle run followed by a full ramp from 0x00.
- R8: During reset, and in every cycle after one in which `test_en` was sampled low, `err_status` is high. Symbols presented while `test_en` is low have no effect.
- R9: Any of these counts as a mismatch and sets `err_status` high: a control character other than the idle code inside the ramp; an idle where a ramp byte is expected; a data byte other than 0x00 directly after an idle.
- R10: `mon_byte`, `mon_ctrl` and `mon_fault` equal `rx_byte`, `rx_ctrl` and `rx_fault` in the same cycle, whether or not the test is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Self-test enable; low holds the checker cleared |
| rx_byte | input | DATA_W | Decoded received byte |
| rx_ctrl | input | 1 | Byte is a control character |
| rx_fault | input | 1 | Code violation or buffer fault on this symbol |
| err_status | output | 1 | 1 = pattern not verified or broken, 0 = pattern received correctly |
| mon_byte | output | DATA_W | Forwarded received byte |
| mon_ctrl | output | 1 | Forwarded control flag |
| mon_fault | output | 1 | Forwarded fault flag |

## Verification
The assertions assume that `rx_byte`, `rx_ctrl`, `rx_fault` and `test_en` carry known values on every sampled edge after reset. They also assume that a cleared status can only follow a sampled all-ones data byte. The bench holds all inputs at defined values from time zero and changes them only on falling edges, so each symbol is sampled on exactly one rising edge. Broken frames are built by corrupting one position of an otherwise correct ramp, so every expected status change can be traced to a single symbol.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    // Tracker position within the frame
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,   // waiting for an idle after start or error
        ST_IDLES = 2'd1,   // inside an idle run, 0x00 may start a ramp
        ST_RAMP  = 2'd2,   // inside the ramp, next byte is the expected value
        ST_TAIL  = 2'd3    // ramp complete, an idle must follow
    } trk_state_e;

    // Classification of one received symbol
    typedef struct packed {
        logic is_idle;     // clean idle control character
        logic is_data;     // clean data byte
        logic is_fault;    // receive fault flagged
    } sym_class_t;

    // Per-cycle verdict of the tracker
    typedef struct packed {
        logic frame_ok;    // final ramp byte accepted
        logic mismatch;    // pattern broken this cycle
    } trk_verdict_t;

    function automatic logic verdict_any(input trk_verdict_t v);
        return v.frame_ok | v.mismatch;
    endfunction

endpackage

// File: rtl/rpc_sym_classify.sv
module rpc_sym_classify
    import rpc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] IDLE_CODE = 8'hBC
) (
    input  logic [DATA_W-1:0] sym_byte,
    input  logic              sym_ctrl,
    input  logic              sym_fault,
    output sym_class_t        cls
);

    always_comb begin
        cls.is_fault = sym_fault;
        cls.is_idle  = sym_ctrl && (sym_byte == IDLE_CODE) && !sym_fault;
        cls.is_data  = !sym_ctrl && !sym_fault;
    end

endmodule

// File: rtl/rpc_seq_tracker.sv
module rpc_seq_tracker
    import rpc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  sym_class_t        cls,
    input  logic [DATA_W-1:0] sym_byte,
    output trk_verdict_t      verdict
);

    localparam logic [DATA_W-1:0] LAST_VAL = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ONE_VAL  = DATA_W'(1);

    trk_state_e        state_q, state_d;
    logic [DATA_W-1:0] exp_q, exp_d;

    always_comb begin
        state_d          = state_q;
        exp_d            = exp_q;
        verdict.frame_ok = 1'b0;
        verdict.mismatch = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (cls.is_idle) state_d = ST_IDLES;
            end
            ST_IDLES: begin
                if (cls.is_idle) begin
                    state_d = ST_IDLES;
                end else if (cls.is_data && sym_byte == '0) begin
                    state_d = ST_RAMP;
                    exp_d   = ONE_VAL;
                end else begin
                    verdict.mismatch = 1'b1;
                end
            end
            ST_RAMP: begin
                if (cls.is_data && sym_byte == exp_q) begin
                    if (exp_q == LAST_VAL) begin
                        verdict.frame_ok = 1'b1;
                        state_d          = ST_TAIL;
                    end else begin
                        exp_d = exp_q + ONE_VAL;
                    end
                end else begin
                    verdict.mismatch = 1'b1;
                end
            end
            ST_TAIL: begin
                if (cls.is_idle) state_d = ST_IDLES;
                else             verdict.mismatch = 1'b1;
            end
            default: state_d = ST_HUNT;
        endcase
        if (verdict.mismatch) begin
            state_d = ST_HUNT;
            exp_d   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state_q <= ST_HUNT;
            exp_q   <= '0;
        end else begin
            state_q <= state_d;
            exp_q   <= exp_d;
        end
    end

    // R3
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RAMP && $past(state_q) == ST_RAMP) |-> (exp_q == $past(exp_q) + ONE_VAL));

    // R6
    tail_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAIL) |-> ($past(state_q) == ST_RAMP && $past(exp_q) == LAST_VAL));

endmodule

// File: rtl/rpc_status_reg.sv
module rpc_status_reg
    import rpc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  trk_verdict_t verdict,
    output logic         err_status
);

    logic active_q;
    logic status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            status_q <= 1'b1;
        end else begin
            active_q <= active;
            if (!active || !active_q)     status_q <= 1'b1;
            else if (verdict.mismatch)    status_q <= 1'b1;
            else if (verdict_any(verdict)) status_q <= 1'b0;
        end
    end

    assign err_status = status_q;

    // R1
    enable_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |=> err_status);

    // R8
    disabled_high_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> err_status);

endmodule

// File: rtl/ramp_pattern_checker.sv
module ramp_pattern_checker
    import rpc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] IDLE_CODE = 8'hBC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_en,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_ctrl,
    input  logic              rx_fault,
    output logic              err_status,
    output logic [DATA_W-1:0] mon_byte,
    output logic              mon_ctrl,
    output logic              mon_fault
);

    sym_class_t   cls;
    trk_verdict_t verdict;

    rpc_sym_classify #(
        .DATA_W   (DATA_W),
        .IDLE_CODE(IDLE_CODE)
    ) u_classify (
        .sym_byte (rx_byte),
        .sym_ctrl (rx_ctrl),
        .sym_fault(rx_fault),
        .cls      (cls)
    );

    rpc_seq_tracker #(
        .DATA_W(DATA_W)
    ) u_tracker (
        .clk     (clk),
        .rst     (rst),
        .active  (test_en),
        .cls     (cls),
        .sym_byte(rx_byte),
        .verdict (verdict)
    );

    rpc_status_reg u_status (
        .clk       (clk),
        .rst       (rst),
        .active    (test_en),
        .verdict   (verdict),
        .err_status(err_status)
    );

    // Normal receive path stays visible during the test
    assign mon_byte  = rx_byte;
    assign mon_ctrl  = rx_ctrl;
    assign mon_fault = rx_fault;

    // R2
    clear_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err_status) |-> ($past(rx_byte) == {DATA_W{1'b1}} && !$past(rx_ctrl)
                               && !$past(rx_fault) && $past(test_en)));

    // R4
    fault_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (test_en && rx_fault) |=> err_status);

    // R10
    forward_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_byte == rx_byte) && (mon_ctrl == rx_ctrl) && (mon_fault == rx_fault));

endmodule

// File: tb/ramp_pattern_checker_test.sv
module ramp_pattern_checker_test;

    localparam logic [7:0] IDLE = 8'hBC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       test_en = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_ctrl = 1'b0;
    logic       rx_fault = 1'b0;
    logic       err_status;
    logic [7:0] mon_byte;
    logic       mon_ctrl;
    logic       mon_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [7:0] b;
        logic       c;
        logic       f;
        logic       st;
    } exp_item_t;

    exp_item_t exp_q[$];
    string     tag_q[$];

    always #10 clk = ~clk;

    ramp_pattern_checker uut (
        .clk(clk), .rst(rst), .test_en(test_en),
        .rx_byte(rx_byte), .rx_ctrl(rx_ctrl), .rx_fault(rx_fault),
        .err_status(err_status),
        .mon_byte(mon_byte), .mon_ctrl(mon_ctrl), .mon_fault(mon_fault)
    );

    // Driver: one symbol per cycle, expected status after the next rising edge
    task automatic drive(input logic en, input logic [7:0] b, input logic c,
                         input logic f, input logic st, input string tag);
        exp_item_t it;
        @(negedge clk);
        test_en  = en;
        rx_byte  = b;
        rx_ctrl  = c;
        rx_fault = f;
        it.b = b; it.c = c; it.f = f; it.st = st;
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    task automatic idles(input int n, input logic st, input string tag);
        for (int i = 0; i < n; i++) drive(1'b1, IDLE, 1'b1, 1'b0, st, tag);
    endtask

    // Full correct ramp: status st_in until 0xFF, then st_end
    task automatic ramp(input logic st_in, input logic st_end, input string tag);
        for (int i = 0; i < 256; i++)
            drive(1'b1, 8'(i), 1'b0, 1'b0, (i == 255) ? st_end : st_in, tag);
    endtask

    // Ramp with one corrupted position; status low before it, high from it on
    task automatic ramp_broken(input int pos, input logic [7:0] b, input logic c,
                               input logic f, input string tag);
        for (int i = 0; i < 256; i++) begin
            if (i == pos)      drive(1'b1, b, c, f, 1'b1, tag);
            else if (i < pos)  drive(1'b1, 8'(i), 1'b0, 1'b0, 1'b0, tag);
            else               drive(1'b1, 8'(i), 1'b0, 1'b0, 1'b1, {tag, "_R7"});
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                string tg;
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (err_status !== it.st) begin
                    errors++;
                    $display("FAIL %s: err_status=%b expected %b", tg, err_status, it.st);
                end
                checks++;
                if (mon_byte !== it.b || mon_ctrl !== it.c || mon_fault !== it.f) begin
                    errors++;
                    $display("FAIL R10: forward=%h/%b/%b expected %h/%b/%b",
                             mon_byte, mon_ctrl, mon_fault, it.b, it.c, it.f);
                end
            end
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (err_status !== 1'b1) begin
            errors++;
            $display("FAIL R8: reset err_status=%b expected 1", err_status);
        end
        @(negedge clk);
        rst = 1'b0;

        // R8: a perfect frame while disabled is ignored
        for (int i = 0; i < 3; i++) drive(1'b0, IDLE, 1'b1, 1'b0, 1'b1, "R8");
        for (int i = 0; i < 256; i++) drive(1'b0, 8'(i), 1'b0, 1'b0, 1'b1, "R8");
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R8");

        // R1 / R2: enable, idles, full ramp clears
        idles(3, 1'b1, "R1");
        ramp(1'b1, 1'b0, "R2");

        // R5: single idle and long idle runs keep it low
        idles(1, 1'b0, "R5");
        ramp(1'b0, 1'b0, "R5");
        idles(7, 1'b0, "R5");
        ramp(1'b0, 1'b0, "R5");

        // R3: wrong data byte at 0x40, then R7 recovery
        idles(2, 1'b0, "R3");
        ramp_broken(8'h40, 8'h41, 1'b0, 1'b0, "R3");
        idles(2, 1'b1, "R7");
        ramp(1'b1, 1'b0, "R7");

        // R4: fault on a correct byte inside the ramp
        idles(1, 1'b0, "R4");
        ramp_broken(8'h10, 8'h10, 1'b0, 1'b1, "R4");
        idles(1, 1'b1, "R7");
        ramp(1'b1, 1'b0, "R7");

        // R4: fault on an idle
        drive(1'b1, IDLE, 1'b1, 1'b1, 1'b1, "R4");
        idles(2, 1'b1, "R7");
        ramp(1'b1, 1'b0, "R7");

        // R6: zero-idle gap straight into 0x00
        drive(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, "R6");
        idles(1, 1'b1, "R7");
        ramp(1'b1, 1'b0, "R7");

        // R9: foreign control char inside ramp
        idles(1, 1'b0, "R9");
        ramp_broken(8'h22, 8'h7C, 1'b1, 1'b0, "R9");
        idles(1, 1'b1, "R7");
        ramp(1'b1, 1'b0, "R7");

        // R9: idle in place of a ramp byte
        idles(1, 1'b0, "R9");
        ramp_broken(8'h80, IDLE, 1'b1, 1'b0, "R9");
        idles(1, 1'b1, "R7");
        ramp(1'b1, 1'b0, "R7");

        // R9: non-zero data right after idle
        idles(2, 1'b0, "R9");
        drive(1'b1, 8'h05, 1'b0, 1'b0, 1'b1, "R9");
        idles(1, 1'b1, "R7");
        ramp(1'b1, 1'b0, "R7");

        // R1: drop enable mid-ramp, resume the ramp after re-enable
        idles(1, 1'b0, "R1");
        for (int i = 0; i < 128; i++) drive(1'b1, 8'(i), 1'b0, 1'b0, 1'b0, "R1");
        drive(1'b0, 8'h80, 1'b0, 1'b0, 1'b1, "R1");
        for (int i = 129; i < 256; i++) drive(1'b1, 8'(i), 1'b0, 1'b0, 1'b1, "R1");
        idles(1, 1'b1, "R1");
        ramp(1'b1, 1'b0, "R1");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule